// File: doc/BRIEF.md
# Response Ring Writer with Interrupt Threshold

This engine sits on the controller side of a codec link. Each response word that arrives from the link comes with an extended word. The engine stores the pair as one 8-byte slot in a circular ring in system memory. It then publishes the index of the newest slot as the hardware write pointer. Software reads entries up to that pointer and parses them.

The engine counts how many entries it has written. When that count reaches a programmed threshold, it sets a response status flag and raises an interrupt if interrupts are enabled. The engine never stalls the link because the host is slow. It writes over old entries and records an overrun instead. While the engine is disabled, it accepts responses and throws them away.

Both data paths are valid/ready. A transfer happens on a clock edge where valid and ready are both high. On the response input, ready drops only while a slot write is still waiting for memory and the memory side is not ready in the same cycle. On the memory write output, valid stays high and address and data stay unchanged until ready is seen. Software programs the engine through a simple register write port. Each register write takes effect at the clock edge where it is presented.

Top module: `rsp_ring_writer`

## Requirements
- R1: While reset is asserted: the write pointer reads 0, memory write valid is low, both status flags are low, the interrupt is low and the busy readback is low. After reset, the ring size code is 2, the threshold is 1 and both enables are off.
- R2: One slot is 8 bytes. The slot written to index i goes to byte address base + 8*i. Data bits 31:0 carry the response word and bits 63:32 carry the extended word exactly as it arrived. The extended word's bits 3:0 (codec address) and bit 4 (unsolicited flag) are stored untouched.
- R3: A response goes to slot (P + 1) mod N. P is the last slot written or queued, and N is set by the size register (register 1, bits 1:0): code 0 means 2 entries, code 1 means 16 entries, codes 2 and 3 mean 256 entries. The write pointer output takes the slot index in the cycle after that slot's memory write is accepted.
- R4: Memory write valid, address and data hold steady until memory write ready is seen. While enabled, response ready is low only when a write is pending and memory write ready is low. With memory always ready, responses are taken on every cycle.
- R5: A write to register 2 with bit 15 set clears the write pointer to 0 in the next cycle. A write to register 2 with bit 15 clear leaves the pointer unchanged.
- R6: The response status flag (status register 5, bit 0) sets in the same cycle the pointer is published for the entry that brings the count of written entries to the threshold (register 3, bits 7:0; a value of 0 means 256). The count then restarts from 0.
- R7: Writing 1 to status bit 0 clears the response flag and resets the entry count. Writing 1 to status bit 2 clears the overrun flag. A clear and a new event in the same cycle leave the flag set.
- R8: The interrupt is high exactly when interrupt enable (control register 4, bit 1) is set and at least one status flag is set.
- R9: An entry written into the slot whose index equals the host read pointer input sets the overrun flag (status bit 2). The engine does not stall in that case.
- R10: While DMA enable (control register 4, bit 0) is clear, response ready is high. Responses taken in that state are discarded: no memory write happens, the pointer does not move and the entry count does not change.
- R11: The busy output is high while DMA enable is set or a slot write is still pending. After DMA enable is cleared, busy goes low in the cycle after the last pending write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register index: 0 base, 1 size, 2 write pointer, 3 threshold, 4 control, 5 status |
| reg_wr_data | input | 32 | Register write data |
| host_rp | input | 8 | Index of the last slot the host has read |
| rsp_valid | input | 1 | Response available |
| rsp_ready | output | 1 | Response taken on this edge when valid is high |
| rsp_data | input | 32 | Response word |
| rsp_ext | input | 32 | Extended word (codec address, unsolicited flag) |
| mem_wr_valid | output | 1 | Slot write request |
| mem_wr_ready | input | 1 | Memory accepts the slot write |
| mem_wr_addr | output | 32 | Byte address of the slot |
| mem_wr_data | output | 64 | Slot contents |
| wp_out | output | 8 | Published write pointer |
| dma_busy | output | 1 | Busy readback: enable set or a write pending |
| st_rsp | output | 1 | Response threshold status flag |
| st_ovr | output | 1 | Overrun status flag |
| irq | output | 1 | Interrupt |

## Verification
The results have these timings:
- A response accepted at edge k shows up as a memory write request in the cycle after edge k.
- When that request is accepted at edge m, the pointer, the status flags and the interrupt change at edge m, and the new values are visible from the next half cycle.
- Register writes and status clears act at the edge where they are presented.

The bench drives inputs on falling edges. At each rising edge it advances a behavioural model with the same sampled inputs. It compares every output halfway between a falling edge and the next rising edge, so each result is checked in exactly the cycle it is due. Targeted checks are made after the pipeline has drained, and they use hard-coded expected values.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  typedef enum logic [2:0] {
    RA_BASE   = 3'd0,
    RA_SIZE   = 3'd1,
    RA_WPTR   = 3'd2,
    RA_THRESH = 3'd3,
    RA_CTRL   = 3'd4,
    RA_STAT   = 3'd5
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IEN_BIT = 1;
  localparam int STAT_RSP_BIT = 0;
  localparam int STAT_OVR_BIT = 2;
  localparam int WPTR_RST_BIT = 15;

  localparam logic [1:0] SZ_TWO     = 2'd0;
  localparam logic [1:0] SZ_SIXTEEN = 2'd1;
  localparam logic [1:0] SZ_FULL    = 2'd2;

  localparam int SLOT_SHIFT = 3;
endpackage

// File: rtl/rrw_regs.sv
module rrw_regs
  import rrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [ADDR_W-1:0] base,
  output logic [1:0]        size_code,
  output logic [PTR_W-1:0]  thresh,
  output logic              run,
  output logic              irq_en,
  output logic              wp_rst,
  output logic              clr_rsp,
  output logic              clr_ovr
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(reg_wr_addr);

  logic hit_base, hit_size, hit_thr, hit_ctrl, hit_wptr, hit_stat;
  always_comb begin
    hit_base = 1'b0;
    hit_size = 1'b0;
    hit_thr  = 1'b0;
    hit_ctrl = 1'b0;
    hit_wptr = 1'b0;
    hit_stat = 1'b0;
    if (reg_wr_en) begin
      unique case (sel)
        RA_BASE:   hit_base = 1'b1;
        RA_SIZE:   hit_size = 1'b1;
        RA_WPTR:   hit_wptr = 1'b1;
        RA_THRESH: hit_thr  = 1'b1;
        RA_CTRL:   hit_ctrl = 1'b1;
        RA_STAT:   hit_stat = 1'b1;
        default:   ;
      endcase
    end
  end

  assign wp_rst  = hit_wptr & reg_wr_data[WPTR_RST_BIT];
  assign clr_rsp = hit_stat & reg_wr_data[STAT_RSP_BIT];
  assign clr_ovr = hit_stat & reg_wr_data[STAT_OVR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base      <= '0;
      size_code <= SZ_FULL;
      thresh    <= PTR_W'(1);
      run       <= 1'b0;
      irq_en    <= 1'b0;
    end else begin
      if (hit_base) base      <= reg_wr_data[ADDR_W-1:0];
      if (hit_size) size_code <= reg_wr_data[1:0];
      if (hit_thr)  thresh    <= reg_wr_data[PTR_W-1:0];
      if (hit_ctrl) begin
        run    <= reg_wr_data[CTRL_RUN_BIT];
        irq_en <= reg_wr_data[CTRL_IEN_BIT];
      end
    end
  end
endmodule

// File: rtl/rrw_engine.sv
module rrw_engine
  import rrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [ADDR_W-1:0]   base,
  input  logic [1:0]          size_code,
  input  logic                wp_rst,
  input  logic [PTR_W-1:0]    host_rp,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [WORD_W-1:0]   rsp_data,
  input  logic [WORD_W-1:0]   rsp_ext,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [ADDR_W-1:0]   mem_wr_addr,
  output logic [2*WORD_W-1:0] mem_wr_data,
  output logic [PTR_W-1:0]    wp,
  output logic                done,
  output logic                ovr_hit,
  output logic                busy
);
  localparam int SLOT_W = 2 * WORD_W;

  logic [PTR_W-1:0]  ring_mask;
  logic [PTR_W-1:0]  wp_q, slot_q, start_ptr, next_slot;
  logic              pend_q;
  logic [SLOT_W-1:0] entry_q;
  logic              mem_fire, rsp_fire, room;

  always_comb begin
    unique case (size_code)
      SZ_TWO:     ring_mask = PTR_W'(1);
      SZ_SIXTEEN: ring_mask = PTR_W'(15);
      default:    ring_mask = '1;
    endcase
  end

  assign mem_fire  = pend_q & mem_wr_ready;
  assign room      = ~pend_q | mem_wr_ready;
  assign rsp_ready = run ? room : 1'b1;
  assign rsp_fire  = rsp_valid & run & room;
  assign start_ptr = pend_q ? slot_q : wp_q;
  assign next_slot = (start_ptr + PTR_W'(1)) & ring_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      slot_q  <= '0;
      entry_q <= '0;
    end else if (rsp_fire) begin
      pend_q  <= 1'b1;
      slot_q  <= next_slot;
      entry_q <= {rsp_ext, rsp_data};
    end else if (mem_fire) begin
      pend_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wp_q <= '0;
    else if (wp_rst)   wp_q <= '0;
    else if (mem_fire) wp_q <= slot_q;
  end

  assign mem_wr_valid = pend_q;
  assign mem_wr_addr  = base + (ADDR_W'(slot_q) << SLOT_SHIFT);
  assign mem_wr_data  = entry_q;
  assign wp           = wp_q;
  assign done         = mem_fire;
  assign ovr_hit      = mem_fire & (slot_q == host_rp);
  assign busy         = run | pend_q;
endmodule

// File: rtl/rrw_irq.sv
module rrw_irq #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             ovr_hit,
  input  logic [PTR_W-1:0] thresh,
  input  logic             irq_en,
  input  logic             clr_rsp,
  input  logic             clr_ovr,
  output logic             st_rsp,
  output logic             st_ovr,
  output logic             irq
);
  localparam int CW = PTR_W + 1;

  logic [CW-1:0] cnt_q, thr_eff, cnt_base, cnt_inc;
  logic          hit;

  assign thr_eff  = (thresh == '0) ? (CW'(1) << PTR_W) : {1'b0, thresh};
  assign cnt_base = clr_rsp ? '0 : cnt_q;
  assign cnt_inc  = cnt_base + CW'(done);
  assign hit      = done & (cnt_inc >= thr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      st_rsp <= 1'b0;
      st_ovr <= 1'b0;
    end else begin
      cnt_q  <= hit ? '0 : cnt_inc;
      st_rsp <= (st_rsp & ~clr_rsp) | hit;
      st_ovr <= (st_ovr & ~clr_ovr) | ovr_hit;
    end
  end

  assign irq = irq_en & (st_rsp | st_ovr);
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
  import rrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 32,
  parameter int REG_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [2:0]          reg_wr_addr,
  input  logic [REG_W-1:0]    reg_wr_data,
  input  logic [PTR_W-1:0]    host_rp,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [WORD_W-1:0]   rsp_data,
  input  logic [WORD_W-1:0]   rsp_ext,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [ADDR_W-1:0]   mem_wr_addr,
  output logic [2*WORD_W-1:0] mem_wr_data,
  output logic [PTR_W-1:0]    wp_out,
  output logic                dma_busy,
  output logic                st_rsp,
  output logic                st_ovr,
  output logic                irq
);
  logic [ADDR_W-1:0] base;
  logic [1:0]        size_code;
  logic [PTR_W-1:0]  thresh;
  logic              run, irq_en, wp_rst, clr_rsp, clr_ovr;
  logic              done, ovr_hit;

  rrw_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .base(base), .size_code(size_code), .thresh(thresh),
    .run(run), .irq_en(irq_en),
    .wp_rst(wp_rst), .clr_rsp(clr_rsp), .clr_ovr(clr_ovr)
  );

  rrw_engine #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .WORD_W(WORD_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .run(run), .base(base), .size_code(size_code), .wp_rst(wp_rst), .host_rp(host_rp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_ext(rsp_ext),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .wp(wp_out), .done(done), .ovr_hit(ovr_hit), .busy(dma_busy)
  );

  rrw_irq #(.PTR_W(PTR_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .done(done), .ovr_hit(ovr_hit), .thresh(thresh), .irq_en(irq_en),
    .clr_rsp(clr_rsp), .clr_ovr(clr_ovr),
    .st_rsp(st_rsp), .st_ovr(st_ovr), .irq(irq)
  );
endmodule

// File: rtl/rrw_checker.sv
module rrw_checker
  import rrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int SLOT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [2:0]        reg_wr_addr,
  input logic              wptr_rst_bit,
  input logic              rsp_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [SLOT_W-1:0] mem_wr_data,
  input logic [PTR_W-1:0]  wp_out,
  input logic              dma_busy,
  input logic              st_rsp,
  input logic              st_ovr,
  input logic              irq
);
  logic ptr_clear_req, slot_taken;
  assign ptr_clear_req = reg_wr_en && (reg_wr_addr == RA_WPTR) && wptr_rst_bit;
  assign slot_taken    = mem_wr_valid && mem_wr_ready;

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_wp_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_clear_req && !slot_taken) |=> (wp_out == '0));

  p_wp_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_out != $past(wp_out)) |-> ($past(slot_taken) || $past(ptr_clear_req)));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_rsp || st_ovr));

  p_drop_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_busy |-> rsp_ready);

  p_busy_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> dma_busy);
endmodule

bind rsp_ring_writer rrw_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .SLOT_W(2*WORD_W)) u_rrw_chk (
  .clk(clk), .rst_n(rst_n),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .wptr_rst_bit(reg_wr_data[15]),
  .rsp_ready(rsp_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .wp_out(wp_out),
  .dma_busy(dma_busy), .st_rsp(st_rsp), .st_ovr(st_ovr), .irq(irq)
);

// File: tb/rsp_ring_writer_tb.sv
module rsp_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [7:0]  host_rp = 8'd200;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [31:0] rsp_data = '0;
  logic [31:0] rsp_ext = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b1;
  logic [31:0] mem_wr_addr;
  logic [63:0] mem_wr_data;
  logic [7:0]  wp_out;
  logic        dma_busy, st_rsp, st_ovr, irq;

  always #4 clk = ~clk;

  rsp_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .host_rp(host_rp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_ext(rsp_ext),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .wp_out(wp_out), .dma_busy(dma_busy), .st_rsp(st_rsp), .st_ovr(st_ovr), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int mem_mode = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory side readiness pattern
  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (mem_mode)
      0: mem_wr_ready <= 1'b1;
      1: mem_wr_ready <= (cyc % 3 == 2);
      default: mem_wr_ready <= 1'b0;
    endcase
  end

  // behavioural reference model
  int          m_wp, m_slot, m_cnt, m_size, m_thr;
  logic [31:0] m_base;
  bit          m_pend, m_run, m_ien, m_srsp, m_sovr;
  logic [63:0] m_data;
  int          ents, startp, nslot, thr_e, c;
  bit          fire, take, rdy, hit, prst, clr_r, clr_o;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wp = 0; m_slot = 0; m_cnt = 0; m_size = 2; m_thr = 1; m_base = '0;
      m_pend = 0; m_run = 0; m_ien = 0; m_srsp = 0; m_sovr = 0; m_data = '0;
    end else begin
      ents   = (m_size == 0) ? 2 : (m_size == 1) ? 16 : 256;
      fire   = m_pend && mem_wr_ready;
      rdy    = !m_run || !m_pend || mem_wr_ready;
      take   = m_run && rsp_valid && rdy;
      startp = m_pend ? m_slot : m_wp;
      nslot  = (startp + 1) % ents;
      prst   = reg_wr_en && reg_wr_addr == 3'd2 && reg_wr_data[15];
      clr_r  = reg_wr_en && reg_wr_addr == 3'd5 && reg_wr_data[0];
      clr_o  = reg_wr_en && reg_wr_addr == 3'd5 && reg_wr_data[2];
      thr_e  = (m_thr == 0) ? 256 : m_thr;
      c = clr_r ? 0 : m_cnt;
      if (fire) c = c + 1;
      hit = fire && (c >= thr_e);
      if (hit) c = 0;
      m_cnt  = c;
      m_srsp = (m_srsp && !clr_r) || hit;
      m_sovr = (m_sovr && !clr_o) || (fire && m_slot == int'(host_rp));
      if (prst) m_wp = 0;
      else if (fire) m_wp = m_slot;
      if (take) begin
        m_pend = 1; m_slot = nslot; m_data = {rsp_ext, rsp_data};
      end else if (fire) m_pend = 0;
      if (reg_wr_en) begin
        case (reg_wr_addr)
          3'd0: m_base = reg_wr_data;
          3'd1: m_size = int'(reg_wr_data[1:0]);
          3'd3: m_thr  = int'(reg_wr_data[7:0]);
          3'd4: begin m_run = reg_wr_data[0]; m_ien = reg_wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, mid low phase
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R3 write pointer", wp_out, m_wp);
      check("R4 mem valid", mem_wr_valid, m_pend);
      if (m_pend) begin
        check("R2 slot address", mem_wr_addr, m_base + 32'(m_slot * 8));
        check("R2 slot data", mem_wr_data, m_data);
      end
      check("R4/R10 rsp ready", rsp_ready, (!m_run || !m_pend || mem_wr_ready));
      check("R6 rsp status", st_rsp, m_srsp);
      check("R9 overrun status", st_ovr, m_sovr);
      check("R8 irq", irq, m_ien && (m_srsp || m_sovr));
      check("R11 busy", dma_busy, m_run || m_pend);
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input logic [31:0] e);
    rsp_valid = 1'b1; rsp_data = d; rsp_ext = e;
    #3;
    while (!rsp_ready) begin
      @(negedge clk);
      #3;
    end
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t0;
    int saved;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wp", wp_out, 0);
    check("R1 mem valid", mem_wr_valid, 0);
    check("R1 st_rsp", st_rsp, 0);
    check("R1 st_ovr", st_ovr, 0);
    check("R1 irq", irq, 0);
    check("R1 busy", dma_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    reg_write(3'd0, 32'h0001_0000);
    reg_write(3'd4, 32'h3);
    // threshold 1: flag after every entry (R6), codec address and unsolicited flag kept (R2)
    send(32'hCAFE_0001, 32'h0000_0013);
    idle(2);
    check("R6 thr1 flag", st_rsp, 1);
    check("R8 irq with flag", irq, 1);
    check("R3 first slot is 1", wp_out, 1);
    reg_write(3'd5, 32'h1);
    check("R7 flag cleared", st_rsp, 0);
    send(32'hCAFE_0002, 32'h0000_0002);
    idle(2);
    check("R3 second slot", wp_out, 2);
    reg_write(3'd5, 32'h1);

    // threshold 4 with counter reset by clear (R6, R7)
    reg_write(3'd3, 32'd4);
    send(32'h11, 32'h1);
    send(32'h12, 32'h1);
    idle(2);
    reg_write(3'd5, 32'h1);
    send(32'h13, 32'h1);
    send(32'h14, 32'h1);
    send(32'h15, 32'h1);
    idle(2);
    check("R7 count restarted by clear", st_rsp, 0);
    send(32'h16, 32'h1);
    idle(2);
    check("R6 flag at fourth entry", st_rsp, 1);
    reg_write(3'd5, 32'h1);

    // full-rate intake (R4)
    t0 = cyc;
    for (int i = 0; i < 4; i++) send(32'h100 + i, 32'h5);
    check("R4 four responses in four cycles", cyc - t0, 4);
    // stalled memory side (R4)
    mem_mode = 1;
    for (int i = 0; i < 6; i++) send(32'h200 + i, 32'h10 + i);
    idle(4);
    mem_mode = 0;
    idle(2);

    // pointer reset bit (R5)
    reg_write(3'd2, 32'h0000_8000);
    check("R5 reset bit clears pointer", wp_out, 0);
    send(32'h300, 32'h0);
    idle(2);
    reg_write(3'd2, 32'h0000_0003);
    idle(1);
    check("R5 write without reset bit ignored", wp_out, 1);

    // two-entry ring (R3)
    reg_write(3'd1, 32'h0);
    reg_write(3'd2, 32'h8000);
    send(32'h400, 32'h0);
    send(32'h401, 32'h0);
    send(32'h402, 32'h0);
    idle(2);
    check("R3 two-entry wrap", wp_out, 1);
    // sixteen-entry ring
    reg_write(3'd1, 32'h1);
    reg_write(3'd2, 32'h8000);
    for (int i = 0; i < 17; i++) send(32'h500 + i, 32'h0);
    idle(2);
    check("R3 sixteen-entry wrap", wp_out, 1);
    reg_write(3'd1, 32'h2);

    // threshold 0 means 256 (R6)
    reg_write(3'd3, 32'd0);
    reg_write(3'd5, 32'h5);
    for (int i = 0; i < 255; i++) send(32'h600 + i, 32'h0);
    idle(2);
    check("R6 no flag at 255", st_rsp, 0);
    send(32'h7FF, 32'h0);
    idle(2);
    check("R6 flag at 256", st_rsp, 1);

    // overrun (R9)
    reg_write(3'd3, 32'd1);
    reg_write(3'd5, 32'h5);
    reg_write(3'd2, 32'h8000);
    host_rp = 8'd1;
    send(32'h800, 32'h0);
    idle(2);
    check("R9 overrun set", st_ovr, 1);
    check("R9 no stall after overrun", rsp_ready, 1);
    reg_write(3'd5, 32'h4);
    check("R7 overrun cleared", st_ovr, 0);
    host_rp = 8'd200;
    reg_write(3'd5, 32'h1);

    // dropped while disabled (R10)
    reg_write(3'd3, 32'd2);
    reg_write(3'd4, 32'h2);
    saved = int'(wp_out);
    send(32'h900, 32'h0);
    send(32'h901, 32'h0);
    send(32'h902, 32'h0);
    idle(1);
    check("R10 pointer unmoved", wp_out, saved);
    check("R10 no memory write", mem_wr_valid, 0);
    reg_write(3'd4, 32'h3);
    send(32'h903, 32'h0);
    idle(2);
    check("R10 drops not counted", st_rsp, 0);
    send(32'h904, 32'h0);
    idle(2);
    check("R10 count resumes", st_rsp, 1);
    reg_write(3'd5, 32'h1);

    // busy readback (R11)
    mem_mode = 2;
    idle(1);
    send(32'hA00, 32'h0);
    reg_write(3'd4, 32'h0);
    check("R11 busy while write pending", dma_busy, 1);
    mem_mode = 0;
    idle(2);
    check("R11 idle after drain", dma_busy, 0);
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule